// File: doc/BRIEF.md
# SD/eMMC Bus Speed Mode Register

This block holds the 3-bit bus speed mode of an SD/eMMC host controller. A timing request arrives as a 3-bit timing code together with a one-cycle strobe. The block translates it into a mode code and latches that code into the mode field of a control register. The mode is presented on a dedicated output and in the register readback. Software may also write the register directly. Bits outside the mode field are plain storage. Reserved mode codes in a direct write are dropped.

A separate enhanced-strobe flag is kept next to the mode. It decides which of the two HS400 variants an HS400 request selects. When the flag is updated while an HS400 variant is already active, the mode moves between the two variants without a new timing request. The PHY settings that each mode implies are handled elsewhere.

Top module: `sdm_speed_mode_ctrl`

## Requirements
- R1: After reset `reg_rdata_o` is all zeros. `mode_o` always equals `reg_rdata_o[2:0]`, the mode field.
- R2: Mode codes are 0 for SD, 2 for eMMC SDR, 3 for eMMC DDR, 4 for HS200, 5 for HS400 and 6 for HS400 with enhanced strobe. `mode_o` never shows 1 or 7.
- R3: A request with `req_valid_i` high sets the mode in the next cycle. The mapping from `req_timing_i` is 3 (eMMC high speed) to 2, 4 (eMMC DDR52) to 3, 5 (HS200) to 4, and 6 (HS400) as in R4. The codes 0, 1, 2 and 7 (SD and other timings) give 0.
- R4: An HS400 request gives 6 if the effective flag is set, and 5 if it is clear. The effective flag is `es_value_i` when `es_valid_i` is high in the same cycle, and the stored flag otherwise.
- R5: With no request pending, an `es_valid_i` update changes the mode in two cases. Mode 5 becomes 6 when the new value is 1. Mode 6 becomes 5 when the new value is 0. Any other mode is unaffected.
- R6: The enhanced-strobe flag resets to 0. It is shown on `es_flag_o` and takes `es_value_i` one cycle after `es_valid_i`.
- R7: A register write (`reg_we_i`) always loads `reg_wdata_i[REG_W-1:3]` into the upper bits. It loads `reg_wdata_i[2:0]` into the mode field only when that value is a legal code.
- R8: A register write whose mode value is 1 or 7 leaves the mode unchanged.
- R9: When sources coincide, the mode field follows the first of these that applies: a timing request, then an enhanced-strobe swap, then a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Timing request strobe |
| req_timing_i | input | 3 | Requested bus timing code |
| es_valid_i | input | 1 | Enhanced-strobe flag update strobe |
| es_value_i | input | 1 | New enhanced-strobe flag value |
| reg_we_i | input | 1 | Direct register write enable |
| reg_wdata_i | input | REG_W | Register write data |
| reg_rdata_o | output | REG_W | Register readback |
| mode_o | output | 3 | Current speed mode code |
| es_flag_o | output | 1 | Stored enhanced-strobe flag |

## Verification
The bench targets several corner cases, each with a distinct failure it would expose:
- Flag updates while HS400 or HS400-ES is active. A design that ignores them keeps the old variant.
- Flag updates while HS200 or SD is active. A design that swaps blindly corrupts those modes.
- An HS400 request in the same cycle as a flag update. A design that uses the stale flag picks the wrong variant.
- Direct writes of the reserved codes 1 and 7. If these leak through, the mode output shows an illegal value.
- Coinciding request, flag update and register write, to expose a wrong priority order.
- Writes that must replace the upper bits even when the mode write is rejected.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  localparam int unsigned MODE_W   = 3;
  localparam int unsigned TIMING_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_SD       = 3'd0,
    MODE_EMMC_SDR = 3'd2,
    MODE_EMMC_DDR = 3'd3,
    MODE_HS200    = 3'd4,
    MODE_HS400    = 3'd5,
    MODE_HS400_ES = 3'd6
  } mode_e;

  typedef enum logic [TIMING_W-1:0] {
    TIM_SD_LEGACY = 3'd0,
    TIM_SD_HS     = 3'd1,
    TIM_SD_UHS    = 3'd2,
    TIM_EMMC_HS   = 3'd3,
    TIM_EMMC_DDR  = 3'd4,
    TIM_HS200     = 3'd5,
    TIM_HS400     = 3'd6,
    TIM_OTHER     = 3'd7
  } timing_e;

  function automatic logic mode_legal(logic [MODE_W-1:0] m);
    return !(m == 3'd1 || m == 3'd7);
  endfunction
endpackage

// File: rtl/sdm_timing_map.sv
module sdm_timing_map
  import sdm_pkg::*;
(
  input  logic [TIMING_W-1:0] timing_i,
  input  logic                es_eff_i,
  output logic [MODE_W-1:0]   mode_o
);
  always_comb begin
    unique case (timing_i)
      TIM_EMMC_HS:  mode_o = MODE_EMMC_SDR;
      TIM_EMMC_DDR: mode_o = MODE_EMMC_DDR;
      TIM_HS200:    mode_o = MODE_HS200;
      TIM_HS400:    mode_o = es_eff_i ? MODE_HS400_ES : MODE_HS400;
      default:      mode_o = MODE_SD;
    endcase
  end
endmodule

// File: rtl/sdm_strobe_flag.sv
module sdm_strobe_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic upd_i,
  input  logic val_i,
  output logic flag_o,
  output logic eff_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (upd_i) flag_q <= val_i;
  end

  assign flag_o = flag_q;
  assign eff_o  = upd_i ? val_i : flag_q;

  p_flag_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> flag_o == $past(val_i));
  p_flag_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(flag_o));
endmodule

// File: rtl/sdm_mode_reg.sv
module sdm_mode_reg
  import sdm_pkg::*;
#(
  parameter int unsigned REG_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [MODE_W-1:0] req_mode_i,
  input  logic              es_upd_i,
  input  logic              es_val_i,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [MODE_W-1:0] mode_o,
  output logic [REG_W-1:0]  rdata_o
);
  localparam int unsigned UP_W = REG_W - MODE_W;

  logic [MODE_W-1:0] mode_q, mode_d;
  logic [UP_W-1:0]   upper_q;
  logic              swap_up, swap_dn;

  assign swap_up = es_upd_i &&  es_val_i && (mode_q == MODE_HS400);
  assign swap_dn = es_upd_i && !es_val_i && (mode_q == MODE_HS400_ES);

  always_comb begin
    mode_d = mode_q;
    if (req_i)                                   mode_d = req_mode_i;
    else if (swap_up)                            mode_d = MODE_HS400_ES;
    else if (swap_dn)                            mode_d = MODE_HS400;
    else if (we_i && mode_legal(wdata_i[MODE_W-1:0])) mode_d = wdata_i[MODE_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_SD;
      upper_q <= '0;
    end else begin
      mode_q <= mode_d;
      if (we_i) upper_q <= wdata_i[REG_W-1:MODE_W];
    end
  end

  assign mode_o  = mode_q;
  assign rdata_o = {upper_q, mode_q};

  p_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_legal(mode_o));
  p_swap_up_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i && es_upd_i && es_val_i && mode_o == MODE_HS400 |=> mode_o == MODE_HS400_ES);
  p_swap_dn_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i && es_upd_i && !es_val_i && mode_o == MODE_HS400_ES |=> mode_o == MODE_HS400);
  p_upper_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rdata_o[REG_W-1:MODE_W] == $past(wdata_i[REG_W-1:MODE_W]));
  p_reserved_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && !mode_legal(wdata_i[MODE_W-1:0]) && !req_i && !es_upd_i |=> $stable(mode_o));
  p_req_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> mode_o == $past(req_mode_i));
endmodule

// File: rtl/sdm_speed_mode_ctrl.sv
module sdm_speed_mode_ctrl
  import sdm_pkg::*;
#(
  parameter int unsigned REG_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [TIMING_W-1:0] req_timing_i,
  input  logic                es_valid_i,
  input  logic                es_value_i,
  input  logic                reg_we_i,
  input  logic [REG_W-1:0]    reg_wdata_i,
  output logic [REG_W-1:0]    reg_rdata_o,
  output logic [MODE_W-1:0]   mode_o,
  output logic                es_flag_o
);
  logic              es_eff;
  logic [MODE_W-1:0] req_mode;

  sdm_strobe_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (es_valid_i),
    .val_i  (es_value_i),
    .flag_o (es_flag_o),
    .eff_o  (es_eff)
  );

  sdm_timing_map u_map (
    .timing_i (req_timing_i),
    .es_eff_i (es_eff),
    .mode_o   (req_mode)
  );

  sdm_mode_reg #(.REG_W(REG_W)) u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_valid_i),
    .req_mode_i (req_mode),
    .es_upd_i   (es_valid_i),
    .es_val_i   (es_value_i),
    .we_i       (reg_we_i),
    .wdata_i    (reg_wdata_i),
    .mode_o     (mode_o),
    .rdata_o    (reg_rdata_o)
  );

  p_field_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == reg_rdata_o[MODE_W-1:0]);
  p_sd_fallback_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !(req_timing_i inside {TIM_EMMC_HS, TIM_EMMC_DDR, TIM_HS200, TIM_HS400})
    |=> mode_o == MODE_SD);
  p_hs400_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_timing_i == TIM_HS400
    |=> mode_o == (($past(es_valid_i) ? $past(es_value_i) : $past(es_flag_o))
                   ? MODE_HS400_ES : MODE_HS400));
endmodule

// File: tb/sdm_speed_mode_ctrl_tb.sv
module sdm_speed_mode_ctrl_tb;
  localparam int REG_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_v = 1'b0;
  logic [2:0]       req_t = '0;
  logic             es_v = 1'b0;
  logic             es_val = 1'b0;
  logic             we = 1'b0;
  logic [REG_W-1:0] wd = '0;
  logic [REG_W-1:0] rdata;
  logic [2:0]       mode;
  logic             esf;

  int n_cmp = 0, n_bad = 0;
  int m_mode = 0, m_flag = 0, m_upper = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sdm_speed_mode_ctrl #(.REG_W(REG_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_v), .req_timing_i(req_t),
    .es_valid_i(es_v), .es_value_i(es_val), .reg_we_i(we), .reg_wdata_i(wd),
    .reg_rdata_o(rdata), .mode_o(mode), .es_flag_o(esf));

  // reference model, one clock step
  task automatic model_step();
    int eff, nm;
    eff = es_v ? int'(es_val) : m_flag;
    nm = m_mode;
    if (req_v) begin
      case (req_t)
        3'd3: nm = 2;
        3'd4: nm = 3;
        3'd5: nm = 4;
        3'd6: nm = eff ? 6 : 5;
        default: nm = 0;
      endcase
    end else if (es_v && es_val && m_mode == 5) nm = 6;
    else if (es_v && !es_val && m_mode == 6) nm = 5;
    else if (we && wd[2:0] != 3'd1 && wd[2:0] != 3'd7) nm = int'(wd[2:0]);
    m_mode = nm;
    if (we) m_upper = int'(wd[REG_W-1:3]);
    if (es_v) m_flag = int'(es_val);
  endtask

  task automatic compare(string tag);
    logic [REG_W-1:0] exp_r;
    exp_r = {m_upper[REG_W-4:0], m_mode[2:0]};
    n_cmp++;
    if (mode !== m_mode[2:0] || rdata !== exp_r || esf !== m_flag[0]) begin
      n_bad++;
      $display("FAIL %s: mode=%0d rdata=%h flag=%0d expected mode=%0d rdata=%h flag=%0d",
               tag, mode, rdata, esf, m_mode, exp_r, m_flag);
    end
  endtask

  task automatic step(input bit rv, input logic [2:0] rt, input bit ev, input bit eval,
                      input bit w, input logic [REG_W-1:0] d, input string tag);
    req_v = rv; req_t = rt; es_v = ev; es_val = eval; we = w; wd = d;
    @(posedge clk);
    #1 model_step();
    @(negedge clk);
    req_v = 0; es_v = 0; we = 0;
    compare(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 reset");
    compare("R6 reset flag");
    rst_n = 1'b1;
    @(negedge clk);
    step(0, 0, 0, 0, 0, 0, "R1 idle");
    // R3 mapping of each timing code
    for (int t = 0; t < 8; t++) step(1, 3'(t), 0, 0, 0, 0, "R3 timing map R2");
    // R4 HS400 with stored flag clear then set
    step(1, 3'd6, 0, 0, 0, 0, "R4 hs400 flag clear");
    step(0, 0, 1, 1, 0, 0, "R5 swap up R6");
    step(0, 0, 1, 0, 0, 0, "R5 swap down");
    step(0, 0, 1, 1, 0, 0, "R5 swap up again");
    step(1, 3'd5, 0, 0, 0, 0, "R3 hs200");
    step(0, 0, 1, 0, 0, 0, "R5 hs200 untouched");
    step(0, 0, 1, 1, 0, 0, "R5 hs200 untouched set");
    step(1, 3'd6, 0, 0, 0, 0, "R4 hs400 flag set");
    step(1, 3'd6, 1, 0, 0, 0, "R4 same-cycle flag clear");
    step(1, 3'd6, 1, 1, 0, 0, "R4 same-cycle flag set");
    step(1, 3'd0, 0, 0, 0, 0, "R3 sd");
    step(0, 0, 1, 0, 0, 0, "R5 sd untouched");
    // R7 / R8 register writes
    step(0, 0, 0, 0, 1, 16'hABC3, "R7 legal write");
    step(0, 0, 0, 0, 1, 16'h1231, "R8 reserved 1");
    step(0, 0, 0, 0, 1, 16'hFFFF, "R8 reserved 7 R7 upper");
    step(0, 0, 0, 0, 1, 16'h0005, "R7 write hs400");
    step(0, 0, 1, 1, 1, 16'h0002, "R9 swap beats write");
    step(1, 3'd3, 1, 0, 1, 16'h0004, "R9 request beats all");
    step(0, 0, 0, 0, 1, 16'h5550, "R7 write sd");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] & r[1], r[4:2], r[5] & r[6], r[7], r[8] & r[9], r[31:16], "R9 random mix");
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule